// File: doc/BRIEF.md
# Bus-Master Storage DMA Control and Status Registers

This block is the host-visible register file of one bus-master storage DMA channel. Software reaches it through a byte-wide read/write port and holds three things there: a control byte that starts or stops a transfer and picks its direction, a status byte that reports progress and faults, and a 32-bit pointer to the descriptor table that the DMA engine walks. The control byte and the pointer go straight to the engine. The engine reports back with three events: the end of the table, a bus error, and an interrupt from the storage device.

The status byte holds three kinds of bit. One bit is set by hardware and software cannot write it: the activity flag. Two bits are sticky flags that software clears by writing a one: the error flag and the interrupt flag. Two bits are plain storage that software uses to note whether each of the two drives can do DMA. The interrupt output is a direct copy of the interrupt flag. A transfer ends well when the low three status bits read 100b.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, and `eng_start`, `eng_dir_read` and `irq_out` are low.
- R2: A write to offset 0 stores bit 0 as the start control and bit 3 as the direction (1 = device to memory). These drive `eng_start` and `eng_dir_read` from the next cycle. A read of offset 0 returns only those two bits, with every other bit 0.
- R3: The activity flag (status bit 0) sets only when a write moves start from 0 to 1. Writing 1 again while start is already 1 does not set it.
- R4: The activity flag clears when `eng_done` is seen or when start is written 0. A clearing event in the same cycle as a start write that would set the flag wins.
- R5: `eng_error` sets the error flag (status bit 1) and clears the activity flag.
- R6: `dev_irq` sets the interrupt flag (status bit 2). `irq_out` equals that flag at all times.
- R7: Writing 1 to status bit 1 or bit 2 clears that flag, and writing 0 leaves it unchanged. A setting event in the same cycle as the clearing write wins.
- R8: Status bits 5 and 6 are read/write storage for drive 0 and drive 1. Writes to status bits 0, 3, 4 and 7 have no effect, and those bits other than bit 0 read as 0.
- R9: The descriptor pointer sits in bytes at offsets 4 to 7, least significant byte first, and drives `tbl_ptr`. Pointer bits 1:0 always read as 0.
- R10: `host_rdata` updates on the clock edge that samples `host_rd` and is valid in the following cycle. Reads have no side effects. Offsets 1 and 3 read 0x00 and ignore writes.
- R11: After a started transfer ends with `eng_done` and a device interrupt, the status byte's low three bits read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| eng_start | output | 1 | Start control to the DMA engine |
| eng_dir_read | output | 1 | Direction, 1 = device to memory |
| tbl_ptr | output | 32 | Descriptor table pointer |
| eng_done | input | 1 | Engine reached end of table |
| eng_error | input | 1 | Engine bus error |
| dev_irq | input | 1 | Device interrupt event |
| irq_out | output | 1 | Interrupt request, mirrors status bit 2 |

## Verification
A wrong flag state reaches the ports in one of two ways. `irq_out` shows an interrupt flag that is wrong in the very next cycle. The activity and error flags are seen only through a status read, one cycle after the read strobe. The bench therefore reads back status after each event and each clearing write, mixes random writes and events across all offsets, and aims directed cases at the edges. Those edges are a second start write while active, an event colliding with a clearing write, stopping mid-transfer, and the alignment bits of the pointer.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int OFF_CMD  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PTR  = 4;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;

  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd (
  input  logic clk,
  input  logic rst,
  input  logic wr_cmd,
  input  logic start_bit,
  input  logic dir_bit,
  input  logic eng_done,
  input  logic eng_error,
  output logic start_q,
  output logic dir_q,
  output logic active_q
);
  logic start_rise, stop_req;

  assign start_rise = wr_cmd & start_bit & ~start_q;
  assign stop_req   = wr_cmd & ~start_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        start_q <= start_bit;
        dir_q   <= dir_bit;
      end
      if (eng_done | eng_error | stop_req)
        active_q <= 1'b0;
      else if (start_rise)
        active_q <= 1'b1;
    end
  end

  // R4: activity can only exist while start is held
  assert_active_needs_start_R4: assert property (@(posedge clk) disable iff (rst)
    active_q |-> start_q);
  // R4 / R5: end or error events drop activity
  assert_end_clears_active_R4: assert property (@(posedge clk) disable iff (rst)
    (eng_done || eng_error) |=> !active_q);
  // R3: a clean 0->1 start write raises activity
  assert_rise_sets_active_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && start_bit && !start_q && !eng_done && !eng_error) |=> active_q);
endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stat,
  input  logic       clr_err,
  input  logic       clr_irq,
  input  logic [1:0] cap_wdata,
  input  logic       eng_error,
  input  logic       dev_irq,
  output logic       err_q,
  output logic       irq_q,
  output logic [1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      if (eng_error)              err_q <= 1'b1;
      else if (wr_stat & clr_err) err_q <= 1'b0;
      if (dev_irq)                irq_q <= 1'b1;
      else if (wr_stat & clr_irq) irq_q <= 1'b0;
      if (wr_stat)                cap_q <= cap_wdata;
    end
  end

  assert_irq_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
    dev_irq |=> irq_q);
  assert_err_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
    eng_error |=> err_q);
  assert_irq_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && clr_irq && !dev_irq) |=> !irq_q);
  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> $stable(cap_q));
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  localparam int PTR_BYTES = PTR_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PTR_BYTES-1:0] wr_byte,
  input  logic [7:0]           wdata,
  output logic [PTR_W-1:0]     ptr_q
);
  localparam logic [PTR_W-1:0] KEEP = {{(PTR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)             ptr_q[b*8 +: 8] <= '0;
      else if (wr_byte[b]) ptr_q[b*8 +: 8] <= wdata & KEEP[b*8 +: 8];
    end
  end

  assert_one_byte_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_byte));
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(|wr_byte) |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  parameter int ADDR_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic             host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             eng_start,
  output logic             eng_dir_read,
  output logic [PTR_W-1:0] tbl_ptr,
  input  logic             eng_done,
  input  logic             eng_error,
  input  logic             dev_irq,
  output logic             irq_out
);
  import bmdma_pkg::*;

  localparam int PTR_BYTES = PTR_W / 8;

  logic wr_cmd, wr_stat;
  logic [PTR_BYTES-1:0] wr_byte;
  logic start_q, dir_q, active_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0] rd_mux;

  assign wr_cmd  = host_we && (host_addr == ADDR_W'(OFF_CMD));
  assign wr_stat = host_we && (host_addr == ADDR_W'(OFF_STAT));

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_dec
    assign wr_byte[b] = host_we && (host_addr == ADDR_W'(OFF_PTR + b));
  end

  bmdma_cmd u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd),
    .start_bit(host_wdata[CMD_START]), .dir_bit(host_wdata[CMD_DIR]),
    .eng_done(eng_done), .eng_error(eng_error),
    .start_q(start_q), .dir_q(dir_q), .active_q(active_q)
  );

  bmdma_stat u_stat (
    .clk(clk), .rst(rst), .wr_stat(wr_stat),
    .clr_err(host_wdata[ST_ERR]), .clr_irq(host_wdata[ST_IRQ]),
    .cap_wdata(host_wdata[ST_CAP1:ST_CAP0]),
    .eng_error(eng_error), .dev_irq(dev_irq),
    .err_q(err_q), .irq_q(irq_q), .cap_q(cap_q)
  );

  bmdma_ptr #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst(rst), .wr_byte(wr_byte), .wdata(host_wdata), .ptr_q(ptr_q)
  );

  always_comb begin
    rd_mux = '0;
    if (host_addr == ADDR_W'(OFF_CMD)) begin
      rd_mux[CMD_START] = start_q;
      rd_mux[CMD_DIR]   = dir_q;
    end
    if (host_addr == ADDR_W'(OFF_STAT)) begin
      rd_mux[ST_ACT]  = active_q;
      rd_mux[ST_ERR]  = err_q;
      rd_mux[ST_IRQ]  = irq_q;
      rd_mux[ST_CAP0] = cap_q[0];
      rd_mux[ST_CAP1] = cap_q[1];
    end
    for (int b = 0; b < PTR_BYTES; b++)
      if (host_addr == ADDR_W'(OFF_PTR + b)) rd_mux = ptr_q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  assign eng_start    = start_q;
  assign eng_dir_read = dir_q;
  assign tbl_ptr      = ptr_q;
  assign irq_out      = irq_q;

  // R10: a status read returns the interrupt flag seen at the read edge
  assert_stat_read_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_W'(OFF_STAT)) |=> host_rdata[ST_IRQ] == $past(irq_out));
  // R10: no read strobe, no change of read data
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 0, host_rd = 0, eng_done = 0, eng_error = 0, dev_irq = 0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic eng_start, eng_dir_read, irq_out;
  logic [31:0] tbl_ptr;

  int checks = 0, failures = 0;
  bit finished = 0;

  // model state
  bit m_start, m_dir, m_act, m_err, m_irq;
  bit [1:0] m_cap;
  bit [31:0] m_ptr;

  always #2 clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_start(eng_start), .eng_dir_read(eng_dir_read), .tbl_ptr(tbl_ptr),
    .eng_done(eng_done), .eng_error(eng_error), .dev_irq(dev_irq), .irq_out(irq_out)
  );

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, m_dir, 2'b0, m_start};
      3'd2: return {1'b0, m_cap, 2'b0, m_irq, m_err, m_act};
      3'd4: return m_ptr[7:0];
      3'd5: return m_ptr[15:8];
      3'd6: return m_ptr[23:16];
      3'd7: return m_ptr[31:24];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit we, input bit rd, input logic [2:0] a, input logic [7:0] d,
                    input bit dn, input bit er, input bit iq, input string tag);
    logic [7:0] exp_rd;
    bit stop, rise, n_start, n_dir, n_act, n_err, n_irq;
    bit [1:0] n_cap;
    bit [31:0] n_ptr;
    host_we = we; host_rd = rd; host_addr = a; host_wdata = d;
    eng_done = dn; eng_error = er; dev_irq = iq;
    exp_rd = model_read(a);
    stop = we && a == 3'd0 && !d[0];
    rise = we && a == 3'd0 && d[0] && !m_start;
    n_start = (we && a == 3'd0) ? d[0] : m_start;
    n_dir   = (we && a == 3'd0) ? d[3] : m_dir;
    n_act   = (dn || er || stop) ? 1'b0 : (rise ? 1'b1 : m_act);
    n_err   = er ? 1'b1 : ((we && a == 3'd2 && d[1]) ? 1'b0 : m_err);
    n_irq   = iq ? 1'b1 : ((we && a == 3'd2 && d[2]) ? 1'b0 : m_irq);
    n_cap   = (we && a == 3'd2) ? d[6:5] : m_cap;
    n_ptr   = m_ptr;
    if (we && a >= 3'd4) n_ptr[(a-4)*8 +: 8] = (a == 3'd4) ? (d & 8'hFC) : d;
    @(posedge clk);
    @(negedge clk);
    m_start = n_start; m_dir = n_dir; m_act = n_act; m_err = n_err;
    m_irq = n_irq; m_cap = n_cap; m_ptr = n_ptr;
    host_we = 0; host_rd = 0; eng_done = 0; eng_error = 0; dev_irq = 0;
    check("R2 eng_start", eng_start, m_start);
    check("R2 eng_dir_read", eng_dir_read, m_dir);
    check("R6 irq_out", irq_out, m_irq);
    check("R9 tbl_ptr", tbl_ptr, m_ptr);
    if (rd) check(tag, host_rdata, exp_rd);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    op(1, 0, a, d, 0, 0, 0, tag);
  endtask

  task automatic rdchk(input logic [2:0] a, input string tag);
    op(0, 1, a, 8'h00, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_out", irq_out, 1'b0);
    check("R1 eng_start", eng_start, 1'b0);
    check("R1 rdata", host_rdata, 8'h00);
    for (int a = 0; a < 8; a++) rdchk(3'(a), "R1 reset read");
    // R2 command byte
    wr(3'd0, 8'hFF, "R2");
    rdchk(3'd0, "R2 cmd readback only bits 0,3");
    rdchk(3'd2, "R3 active after start rise");
    // R3 rewrite of 1 while active, then after done
    wr(3'd0, 8'h09, "R3");
    op(0, 0, 3'd0, 8'h00, 1, 0, 0, "R4");
    rdchk(3'd2, "R4 done clears active");
    wr(3'd0, 8'h09, "R3");
    rdchk(3'd2, "R3 second start write no re-set");
    // R11 good completion
    op(0, 0, 3'd0, 8'h00, 0, 0, 1, "R6");
    rdchk(3'd2, "R11 completion status 100b");
    // R7 W1C
    wr(3'd2, 8'h00, "R7");
    rdchk(3'd2, "R7 write 0 keeps irq");
    wr(3'd2, 8'h04, "R7");
    rdchk(3'd2, "R7 write 1 clears irq");
    op(1, 0, 3'd2, 8'h04, 0, 0, 1, "R7");
    rdchk(3'd2, "R7 event beats clear");
    // R5 error
    wr(3'd0, 8'h00, "R4");
    wr(3'd0, 8'h01, "R3");
    op(0, 0, 3'd0, 8'h00, 0, 1, 0, "R5");
    rdchk(3'd2, "R5 error sets flag clears active");
    op(1, 0, 3'd2, 8'h02, 0, 1, 0, "R7");
    rdchk(3'd2, "R7 error event beats clear");
    wr(3'd2, 8'h06, "R7");
    rdchk(3'd2, "R7 both flags cleared");
    // R8 capability bits
    wr(3'd2, 8'h60, "R8");
    rdchk(3'd2, "R8 cap bits stored");
    wr(3'd2, 8'hB9, "R8");
    rdchk(3'd2, "R8 other bits ignored");
    // R9 pointer
    wr(3'd4, 8'hFF, "R9"); wr(3'd5, 8'h12, "R9");
    wr(3'd6, 8'h34, "R9"); wr(3'd7, 8'h56, "R9");
    for (int a = 4; a < 8; a++) rdchk(3'(a), "R9 pointer byte");
    // R10 holes
    wr(3'd1, 8'hFF, "R10"); wr(3'd3, 8'hFF, "R10");
    rdchk(3'd1, "R10 hole 1"); rdchk(3'd3, "R10 hole 3");
    rdchk(3'd0, "R10 hole writes ignored");
    // R4 stop mid-transfer, and collision
    wr(3'd0, 8'h00, "R4"); wr(3'd0, 8'h01, "R3");
    rdchk(3'd2, "R3 active");
    wr(3'd0, 8'h00, "R4");
    rdchk(3'd2, "R4 stop clears active");
    op(1, 0, 3'd0, 8'h01, 1, 0, 0, "R4");
    rdchk(3'd2, "R4 done beats start rise");
    // random mix
    for (int i = 0; i < 600; i++) begin
      bit we, rd, dn, er, iq;
      we = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      dn = ($urandom % 8) == 0;
      er = ($urandom % 16) == 0;
      iq = ($urandom % 8) == 0;
      op(we, rd, 3'($urandom), 8'($urandom), dn, er, iq, "R10 random read");
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule